// File: doc/BRIEF.md
# Dual-Output Clock Post-Divider with Clean Stop

This block sits after a frequency synthesizer and derives two output clocks from one fast source clock. Output A is the source divided by an even ratio, picked by a 3-bit code from a fixed set of seven values, always at 50% duty. Output B either repeats output A edge for edge or runs at half its rate, and both come from one shared counter so their rising edges line up. A bypass input swaps the source from the synthesizer clock to the reference clock, which lets the dividers run without the loop.

Each output has its own active-low stop input. A stop request goes through a two-flop synchronizer on the source clock and takes effect only at that output's period boundary, where the output is already low. No high pulse is ever cut short, and restarting always begins with a full-width pulse. Changes to the ratio code or the B-rate control wait for a period boundary in the same way. Reset is synchronous and active high. It forces both outputs low and restarts the counter from a fixed phase.

Top module: `clk_postdiv`

## Requirements
- R1: The ratio code sets the half-period K in source cycles as follows: 000 gives K=1, 001 gives K=2, 010 gives K=4, 011 gives K=8, 100 gives K=3, 101 gives K=6, 110 gives K=16. Output A is high for K source cycles and low for K source cycles.
- R2: When `b_half` is 0, output B has the same high and low widths as output A, and it rises on the same source edge.
- R3: When `b_half` is 1, output B is high for 2K and low for 2K source cycles, and each rising edge of B coincides with a rising edge of A.
- R4: Ratio code 111 behaves the same as code 110, with K=16.
- R5: A change to the ratio code takes effect only at the next output-A period boundary. Every high or low interval of output A has the width of either the old setting or the new setting, and output A rises only at the start of a counter period.
- R6: After `stop_a_n` goes low, a high pulse already in progress on output A completes at full width, and output A then stays low.
- R7: After `stop_a_n` returns high, output A rises within R+3 source cycles, where R=2K, and its first high pulse is K source cycles wide.
- R8: With `b_half` at 1, lowering `stop_b_n` lets a high pulse of output B already in progress complete its full 2K cycles, after which output B stays low.
- R9: While `rst` is high, both outputs are low after the next source edge. With both stop inputs high, output A first rises on the R-th source edge that samples `rst` low.
- R10: When `bypass` is 1, the source is `clk_ref`, so the high time of output A is K periods of `clk_ref`.
- R11: Stopping one output does not stop the other output from toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pll | input | 1 | Synthesizer clock, the source when bypass is 0 |
| clk_ref | input | 1 | Reference clock, the source when bypass is 1 |
| bypass | input | 1 | Source select, static during operation |
| rst | input | 1 | Synchronous active-high reset on the selected source |
| ratio_sel | input | 3 | Division ratio code, see R1 |
| b_half | input | 1 | 0: B repeats A; 1: B runs at half the rate of A |
| stop_a_n | input | 1 | Active-low stop for output A, asynchronous |
| stop_b_n | input | 1 | Active-low stop for output B, asynchronous |
| qa | output | 1 | Output clock A |
| qb | output | 1 | Output clock B |

## Verification
The assertions assume that `bypass` is changed only while `rst` is high, so the source clock never switches in the middle of a count. They also assume that reset is held for at least two source edges with the stop inputs steady, so that the synchronizer holds the real stop level before counting starts. The bench follows both rules. It changes the source only inside a long reset window, and it drives every control input at the falling edge of the synthesizer clock. Ratio codes, the B-rate control and the stop inputs may change at any time, because the block itself defers their effect to a period boundary.

// File: rtl/clk_postdiv_pkg.sv
package clk_postdiv_pkg;
  localparam int SEL_W = 3;

  // half-period in source cycles for each ratio code
  function automatic logic [7:0] half_of(input logic [SEL_W-1:0] code);
    case (code)
      3'b000:  half_of = 8'd1;
      3'b001:  half_of = 8'd2;
      3'b010:  half_of = 8'd4;
      3'b011:  half_of = 8'd8;
      3'b100:  half_of = 8'd3;
      3'b101:  half_of = 8'd6;
      default: half_of = 8'd16;
    endcase
  endfunction
endpackage

// File: rtl/clk_postdiv_src_sel.sv
module clk_postdiv_src_sel (
  input  logic clk_a,
  input  logic clk_b,
  input  logic sel_b,
  output logic clk_o
);
  // static select; changed only under reset
  assign clk_o = sel_b ? clk_b : clk_a;
endmodule

// File: rtl/clk_postdiv_sync.sv
module clk_postdiv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  // plain flops: the level settles while reset is held
  always_ff @(posedge clk) chain <= {chain[STAGES-2:0], d};
  assign q = chain[STAGES-1];
endmodule

// File: rtl/clk_postdiv_core.sv
module clk_postdiv_core
  import clk_postdiv_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             b_half,
  input  logic             run_a,
  input  logic             run_b,
  output logic             qa_o,
  output logic             qb_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt, half_q, half_nxt, last_cnt;
  logic nb_q, nb_nxt, ph_q, ph_nxt;
  logic ena_q, ena_nxt, enb_q, enb_nxt;
  logic wrap, b_bound, qa_raw, qb_raw;

  always_comb begin
    last_cnt = CNT_W'({half_q, 1'b0} - (CNT_W+1)'(1));
    wrap     = (cnt_q == last_cnt);
    b_bound  = wrap & (~nb_q | ph_q);
    cnt_nxt  = wrap ? '0 : cnt_q + CNT_W'(1);
    half_nxt = wrap ? CNT_W'(half_of(ratio_sel)) : half_q;
    ph_nxt   = wrap ? ~ph_q : ph_q;
    nb_nxt   = b_bound ? b_half : nb_q;
    ena_nxt  = wrap ? run_a : ena_q;
    enb_nxt  = b_bound ? run_b : enb_q;
    qa_raw   = (cnt_nxt < half_nxt);
    qb_raw   = nb_nxt ? ~ph_nxt : qa_raw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      half_q <= CNT_W'(half_of(ratio_sel));
      nb_q   <= b_half;
      ph_q   <= 1'b1;
      ena_q  <= 1'b0;
      enb_q  <= 1'b0;
      qa_o   <= 1'b0;
      qb_o   <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      half_q <= half_nxt;
      nb_q   <= nb_nxt;
      ph_q   <= ph_nxt;
      ena_q  <= ena_nxt;
      enb_q  <= enb_nxt;
      qa_o   <= ena_nxt & qa_raw;
      qb_o   <= enb_nxt & qb_raw;
    end
  end
endmodule

// File: rtl/clk_postdiv.sv
module clk_postdiv
  import clk_postdiv_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_pll,
  input  logic             clk_ref,
  input  logic             bypass,
  input  logic             rst,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             b_half,
  input  logic             stop_a_n,
  input  logic             stop_b_n,
  output logic             qa,
  output logic             qb
);
  localparam int N_OUT = 2;

  logic             src_clk;
  logic [N_OUT-1:0] stop_v, run_v;

  assign stop_v = {stop_b_n, stop_a_n};

  clk_postdiv_src_sel u_sel (
    .clk_a (clk_pll),
    .clk_b (clk_ref),
    .sel_b (bypass),
    .clk_o (src_clk)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_sync
    clk_postdiv_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (src_clk),
      .d   (stop_v[i]),
      .q   (run_v[i])
    );
  end

  clk_postdiv_core #(.CNT_W(CNT_W)) u_core (
    .clk       (src_clk),
    .rst       (rst),
    .ratio_sel (ratio_sel),
    .b_half    (b_half),
    .run_a     (run_v[0]),
    .run_b     (run_v[1]),
    .qa_o      (qa),
    .qb_o      (qb)
  );
endmodule

// File: rtl/clk_postdiv_chk.sv
module clk_postdiv_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             qa,
  input logic             qb,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] half,
  input logic             nb
);
  logic [CNT_W:0] hi_a, hi_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_a <= '0;
      hi_b <= '0;
    end else begin
      hi_a <= qa ? hi_a + (CNT_W+1)'(1) : '0;
      hi_b <= qb ? hi_b + (CNT_W+1)'(1) : '0;
    end
  end

  // R5: output A starts a pulse only at the start of a counter period
  p_qa_rise_at_start_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(qa) |-> (cnt == '0));

  // R3: output B rises only where output A's period starts
  p_qb_rise_at_start_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(qb) |-> (cnt == '0));

  // R1: every high pulse of A lasts exactly the active half-period
  p_qa_width_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(qa) |-> (hi_a == {1'b0, half}));

  // R2: in equal-rate mode B's high pulse matches the half-period too
  p_qb_width_r2: assert property (@(posedge clk) disable iff (rst)
    ($fell(qb) && !nb) |-> (hi_b == {1'b0, half}));
endmodule

bind clk_postdiv_core clk_postdiv_chk #(.CNT_W(CNT_W)) chk_i (
  .clk  (clk),
  .rst  (rst),
  .qa   (qa_o),
  .qb   (qb_o),
  .cnt  (cnt_q),
  .half (half_q),
  .nb   (nb_q)
);

// File: tb/clk_postdiv_tb.sv
`timescale 1ns/1ps
module clk_postdiv_tb_top;
  localparam int PLL_T = 10;
  localparam int REF_T = 26;

  typedef struct packed {
    logic [2:0] sel;
    logic       nb;
    logic [5:0] k;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 1'b0, 6'd1},  '{3'b001, 1'b0, 6'd2},  '{3'b010, 1'b0, 6'd4},
    '{3'b011, 1'b0, 6'd8},  '{3'b100, 1'b0, 6'd3},  '{3'b101, 1'b0, 6'd6},
    '{3'b110, 1'b0, 6'd16}, '{3'b111, 1'b0, 6'd16}, '{3'b100, 1'b1, 6'd3},
    '{3'b001, 1'b1, 6'd2},  '{3'b000, 1'b1, 6'd1}
  };

  logic clk_pll = 0, clk_ref = 0, bypass = 0, rst = 1, b_half = 0;
  logic stop_a_n = 1, stop_b_n = 1;
  logic [2:0] ratio_sel = 3'b001;
  logic qa, qb;
  int total = 0, bad = 0;

  always #(PLL_T/2) clk_pll = ~clk_pll;
  always #(REF_T/2) clk_ref = ~clk_ref;

  clk_postdiv dut_i (
    .clk_pll(clk_pll), .clk_ref(clk_ref), .bypass(bypass), .rst(rst),
    .ratio_sel(ratio_sel), .b_half(b_half),
    .stop_a_n(stop_a_n), .stop_b_n(stop_b_n), .qa(qa), .qb(qb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic negs(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_pll);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    time t0, t1, t2, tp;
    int n, d, rises;
    bit low_ok;

    // R9: reset state and restart phase (K=2, R=4)
    negs(4);
    chk(!qa && !qb, "R9 reset low", {qa, qb}, 0);
    rst = 0;
    n = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk_pll);
      if (qa) begin n = i; break; end
    end
    chk(n == 4, "R9 first rise edge", n, 4);

    // R1 R2 R3 R4: vector walk
    foreach (VECS[v]) begin
      @(negedge clk_pll);
      ratio_sel = VECS[v].sel;
      b_half = VECS[v].nb;
      repeat (3) @(posedge qb);
      @(posedge qa); t0 = $time; @(negedge qa); t1 = $time; @(posedge qa); t2 = $time;
      chk(int'(t1 - t0) == VECS[v].k * PLL_T, "R1 R4 qa high", int'(t1 - t0), VECS[v].k * PLL_T);
      chk(int'(t2 - t1) == VECS[v].k * PLL_T, "R1 R4 qa low", int'(t2 - t1), VECS[v].k * PLL_T);
      @(posedge qb); t0 = $time; #1;
      chk(qa == 1'b1, "R2 R3 qb rise aligned", qa, 1);
      @(negedge qb); t1 = $time; @(posedge qb); t2 = $time;
      d = (VECS[v].nb ? 2 : 1) * VECS[v].k * PLL_T;
      chk(int'(t1 - t0) == d, "R2 R3 qb high", int'(t1 - t0), d);
      chk(int'(t2 - t1) == d, "R2 R3 qb low", int'(t2 - t1), d);
    end

    // R5: ratio change 2 -> 8 and back, only old or new widths
    @(negedge clk_pll); ratio_sel = 3'b001; b_half = 0;
    repeat (3) @(posedge qa);
    @(negedge clk_pll); ratio_sel = 3'b011;
    @(qa); tp = $time;
    for (int i = 0; i < 6; i++) begin
      @(qa); d = int'($time - tp); tp = $time;
      chk(d == 20 || d == 80, "R5 width up", d, 80);
    end
    chk(d == 80, "R5 new width", d, 80);
    @(posedge qa); negs(2); ratio_sel = 3'b001;
    @(qa); tp = $time;
    for (int i = 0; i < 6; i++) begin
      @(qa); d = int'($time - tp); tp = $time;
      chk(d == 20 || d == 80, "R5 width down", d, 20);
    end

    // R6 R11: stop A mid-pulse, B keeps running (K=2)
    @(posedge qa); t0 = $time;
    @(negedge clk_pll); stop_a_n = 0;
    @(negedge qa); t1 = $time;
    chk(int'(t1 - t0) == 20, "R6 last pulse full", int'(t1 - t0), 20);
    negs(8);
    low_ok = 1; rises = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk_pll);
      if (qa) low_ok = 0;
      if (qb) rises++;
    end
    chk(low_ok, "R6 qa held low", qa, 0);
    chk(rises > 0, "R11 qb still runs", rises, 12);

    // R7: release A
    @(negedge clk_pll); stop_a_n = 1; t0 = $time;
    @(posedge qa); t1 = $time; @(negedge qa); t2 = $time;
    chk(int'(t1 - t0) <= 7 * PLL_T, "R7 restart latency", int'(t1 - t0), 7 * PLL_T);
    chk(int'(t2 - t1) == 20, "R7 first pulse full", int'(t2 - t1), 20);

    // R8 R11: stop B in half-rate mode (K=3)
    @(negedge clk_pll); ratio_sel = 3'b100; b_half = 1;
    repeat (3) @(posedge qb);
    @(posedge qb); t0 = $time;
    @(negedge clk_pll); stop_b_n = 0;
    @(negedge qb); t1 = $time;
    chk(int'(t1 - t0) == 60, "R8 last pulse full", int'(t1 - t0), 60);
    negs(20);
    low_ok = 1; rises = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_pll);
      if (qb) low_ok = 0;
      if (qa) rises++;
    end
    chk(low_ok, "R8 qb held low", qb, 0);
    chk(rises > 0, "R11 qa still runs", rises, 15);
    @(negedge clk_pll); stop_b_n = 1;

    // R9: reset mid-run forces outputs low
    @(posedge qa); @(negedge clk_pll); rst = 1;
    negs(2);
    chk(!qa && !qb, "R9 mid-run reset", {qa, qb}, 0);

    // R10: bypass to reference clock (K=2)
    ratio_sel = 3'b001; b_half = 0; bypass = 1;
    negs(20); rst = 0;
    repeat (3) @(posedge qa);
    @(posedge qa); t0 = $time; @(negedge qa); t1 = $time; @(posedge qa); t2 = $time;
    chk(int'(t1 - t0) == 2 * REF_T, "R10 bypass high", int'(t1 - t0), 2 * REF_T);
    chk(int'(t2 - t0) == 4 * REF_T, "R10 bypass period", int'(t2 - t0), 4 * REF_T);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule